// File: doc/BRIEF.md
# Task-Based Memory Address Translator

This block sits between a CPU with a 16-bit address bus and a 1 MB physical memory system. The logical space is cut into sixteen 4 KB pages, and each page is redirected through an 8-bit physical page number. Seventeen register sets hold these page numbers. Sixteen belong to software tasks. The seventeenth is a boot-time identity map, and it is in force whenever mapping is switched off.

A control port written by the CPU does three things: it picks a task, it switches mapping on or off, and it drives an active-low NMI line towards a second processor. The sixteen page registers of the context in force appear to the CPU at logical $FE00-$FE0F, where they can be read and written. Translation is combinational. Every logical address yields a physical address together with a one-hot choice of RAM, boot ROM or I/O region. The top 256 bytes of logical space always reach the end of the boot ROM.

Top module: `task_mmu`

## Requirements
- R1: After reset, mapping is disabled and the default context is in force: logical page n (0 to 14) goes to physical page n in RAM, logical page 15 goes to ROM page $FF, and nmi_n is 1. Every task register reads as 0 once its task is selected.
- R2: When the page number chosen for the current logical page is $00-$BF, ram_sel is 1 and phys_addr equals {page number, cpu_addr[11:0]}.
- R3: When the page number is $FC-$FF, rom_sel is 1 and rom_offset equals {page[1:0], cpu_addr[11:0]}. A CPU write to such a page gives ram_we = 0, so the write is ignored.
- R4: When the page number is $C0-$FB, rom_sel is 1 and rom_offset equals {2'b00, cpu_addr[11:0]}, which is the first 4 KB of boot ROM.
- R5: Logical $FC00-$FEFF is the I/O region. There io_sel is 1 and both ram_sel and rom_sel are 0. At most one of ram_sel, rom_sel and io_sel is ever 1. Page 15 is translated only for $F000-$FBFF.
- R6: Logical $FF00-$FFFF always gives rom_sel = 1 and rom_offset = $3F00 + cpu_addr[7:0], whatever the context.
- R7: A CPU write with cpu_addr in $FE00-$FE0F stores cpu_wdata into entry cpu_addr[3:0] of the context in force, from the next clock edge on. While cpu_addr is in that window, win_sel is 1 and win_rdata returns the entry combinationally.
- R8: A control write with bit 6 = 0 puts task bits 3:0 in force. A control write with bit 6 = 1 puts the default context in force, and the task bits then have no effect on translation.
- R9: Writes into one context leave every other context, the default one included, unchanged.
- R10: nmi_n takes bit 7 of each control write, where 0 asserts NMI. nmi_n holds its value between control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: [3:0] task, [6] mapping off, [7] NMI level |
| phys_addr | output | 20 | Physical address {page, offset} |
| ram_sel | output | 1 | RAM selected |
| ram_we | output | 1 | Write strobe to RAM |
| rom_sel | output | 1 | Boot ROM selected |
| rom_offset | output | 14 | Byte offset into the 16 KB boot ROM |
| io_sel | output | 1 | I/O region selected |
| win_sel | output | 1 | Page register window hit |
| win_rdata | output | 8 | Page register read data |
| nmi_n | output | 1 | Active-low NMI to second processor |

## Verification
The bench builds the block with its default boundaries: RAM ends at page $BF and ROM begins at page $FC. With these values the random page numbers fall into all three classes, RAM, ROM and undefined-to-first-ROM-page. Random control values cover every task and both mapping states, so the bench reaches task isolation, the hand-over between a task and the default context, and the fixed top window against arbitrary register contents.

// File: rtl/task_mmu.sv
module task_mmu #(
  parameter logic [7:0] RAM_LAST  = 8'hBF,
  parameter logic [7:0] ROM_FIRST = 8'hFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [19:0] phys_addr,
  output logic        ram_sel,
  output logic        ram_we,
  output logic        rom_sel,
  output logic [13:0] rom_offset,
  output logic        io_sel,
  output logic        win_sel,
  output logic [7:0]  win_rdata,
  output logic        nmi_n
);
  localparam int PAGES = 16;
  localparam int CTXS  = PAGES + 1;
  localparam int DEF   = CTXS - 1;
  localparam int CW    = $clog2(CTXS);

  logic [7:0]    map_q [CTXS][PAGES];
  logic [CW-1:0] act_q;
  logic [7:0]    ppage;
  logic          top_win, is_ram, is_rom, unused_ctl;

  assign unused_ctl = ^ctl_wdata[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= CW'(DEF);
      nmi_n <= 1'b1;
    end else if (ctl_we) begin
      act_q <= ctl_wdata[6] ? CW'(DEF) : CW'(ctl_wdata[3:0]);
      nmi_n <= ctl_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CTXS; c++)
        for (int p = 0; p < PAGES; p++)
          map_q[c][p] <= (c != DEF) ? 8'h00 : (p == PAGES - 1) ? 8'hFF : 8'(p);
    end else if (cpu_we && win_sel) begin
      map_q[act_q][cpu_addr[3:0]] <= cpu_wdata;
    end
  end

  assign top_win = &cpu_addr[15:8];
  assign io_sel  = (cpu_addr[15:10] == 6'b111111) && !top_win;
  assign win_sel = (cpu_addr[15:4] == 12'hFE0);
  assign ppage   = map_q[act_q][cpu_addr[15:12]];
  assign is_ram  = ppage <= RAM_LAST;
  assign is_rom  = ppage >= ROM_FIRST;

  assign ram_sel   = !io_sel && !top_win && is_ram;
  assign rom_sel   = top_win || (!io_sel && !is_ram);
  assign ram_we    = cpu_we && ram_sel;
  assign win_rdata = map_q[act_q][cpu_addr[3:0]];
  assign phys_addr = top_win ? {8'hFF, cpu_addr[11:0]} : {ppage, cpu_addr[11:0]};

  always_comb begin
    if (top_win)     rom_offset = {6'h3F, cpu_addr[7:0]};
    else if (is_rom) rom_offset = {ppage[1:0], cpu_addr[11:0]};
    else             rom_offset = {2'b00, cpu_addr[11:0]};
  end
endmodule

// File: rtl/task_mmu_chk.sv
module task_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic        ctl_we,
  input logic [19:0] phys_addr,
  input logic        ram_sel,
  input logic        ram_we,
  input logic        rom_sel,
  input logic [13:0] rom_offset,
  input logic        io_sel,
  input logic        win_sel,
  input logic [7:0]  win_rdata,
  input logic        nmi_n
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel, io_sel})); // R5
  AST_TOP_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hFF00) |-> (rom_sel && rom_offset[13:8] == 6'h3F && rom_offset[7:0] == cpu_addr[7:0])); // R6
  AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_we && ram_sel && !rom_sel)); // R3
  AST_RAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (phys_addr[19:12] <= 8'hBF && phys_addr[11:0] == cpu_addr[11:0])); // R2
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(nmi_n)); // R10
  AST_WIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_we && win_sel && !ctl_we) && cpu_addr == $past(cpu_addr)) |-> win_rdata == $past(cpu_wdata)); // R7
endmodule

bind task_mmu task_mmu_chk chk_i (.*);

// File: tb/task_mmu_tb_top.sv
`timescale 1ns/1ps
module task_mmu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [19:0] phys_addr;
  logic        ram_sel, ram_we, rom_sel, io_sel, win_sel, nmi_n;
  logic [13:0] rom_offset;
  logic [7:0]  win_rdata;

  int vecs = 0;
  int errs = 0;

  logic [7:0] mdl [17][16];
  int         mact;
  logic       mnmi;

  always #2.5 clk = ~clk;

  task_mmu dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd_page();
    case ($urandom_range(0, 2))
      0:       return 8'($urandom_range(0, 'hBF));
      1:       return 8'($urandom_range('hC0, 'hFB));
      default: return 8'($urandom_range('hFC, 'hFF));
    endcase
  endfunction

  task automatic do_ctl(input logic [7:0] d);
    @(negedge clk);
    ctl_wdata = d; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    mact = d[6] ? 16 : int'(d[3:0]);
    mnmi = d[7];
  endtask

  task automatic do_win(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = {12'hFE0, idx}; cpu_wdata = d; cpu_we = 1'b1;
    #1 chk("R7 window write not RAM", {31'd0, ram_we}, 0);
    @(negedge clk);
    cpu_we = 1'b0;
    mdl[mact][idx] = d;
  endtask

  task automatic probe(input logic [15:0] a, input bit we);
    logic top, io, eram, erom, win;
    logic [7:0] pg;
    logic [13:0] eoff;
    win = (a[15:4] == 12'hFE0);
    @(negedge clk);
    cpu_addr = a; cpu_we = we && !win;
    #1;
    top  = a >= 16'hFF00;
    io   = (a >= 16'hFC00) && !top;
    pg   = mdl[mact][a[15:12]];
    eram = !io && !top && (pg <= 8'hBF);
    erom = top || (!io && pg > 8'hBF);
    if (top)              eoff = 14'h3F00 | 14'(a[7:0]);
    else if (pg >= 8'hFC) eoff = {pg[1:0], a[11:0]};
    else                  eoff = {2'b00, a[11:0]};
    chk("R2 ram_sel", {31'd0, ram_sel}, {31'd0, eram});
    chk("R4 rom_sel", {31'd0, rom_sel}, {31'd0, erom});
    chk("R5 io_sel", {31'd0, io_sel}, {31'd0, io});
    chk("R3 ram_we", {31'd0, ram_we}, {31'd0, eram && we && !win});
    if (eram) chk("R2 phys_addr", {12'd0, phys_addr}, {12'd0, pg, a[11:0]});
    if (erom) chk(top ? "R6 rom_offset" : "R3 rom_offset", {18'd0, rom_offset}, {18'd0, eoff});
    chk("R7 win_sel", {31'd0, win_sel}, {31'd0, win});
    if (win) chk("R7 win_rdata", {24'd0, win_rdata}, {24'd0, mdl[mact][a[3:0]]});
    chk("R10 nmi_n", {31'd0, nmi_n}, {31'd0, mnmi});
    cpu_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    for (int c = 0; c < 17; c++)
      for (int p = 0; p < 16; p++)
        mdl[c][p] = (c < 16) ? 8'h00 : (p == 15) ? 8'hFF : 8'(p);
    mact = 16; mnmi = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 default map after reset
    for (int p = 0; p < 16; p++) probe({4'(p), 12'h123}, 1'b0);
    probe(16'hF000, 1'b0);
    chk("R1 page15 to ROM FF", {18'd0, rom_offset}, 32'h3000);
    probe(16'hFE0F, 1'b0);
    chk("R1 default win entry15", {24'd0, win_rdata}, 32'hFF);
    chk("R1 nmi_n idle", {31'd0, nmi_n}, 1);

    // R8 task 5 enabled, all zero
    do_ctl(8'h85);
    probe(16'h3456, 1'b0);
    chk("R1 task regs zero", {12'd0, phys_addr}, 32'h00456);
    // R4 undefined page to first ROM page
    do_win(4'h2, 8'hC5);
    probe(16'h2ABC, 1'b0);
    chk("R4 undefined page", {18'd0, rom_offset}, 32'h0ABC);
    // R3 ROM page and ignored write
    do_win(4'h3, 8'hFD);
    probe(16'h3ABC, 1'b1);
    chk("R3 rom write ignored", {31'd0, ram_we}, 0);
    chk("R3 rom page FD", {18'd0, rom_offset}, 32'h1ABC);
    // R5 page 15 mapped below FC00, I/O above
    do_win(4'hF, 8'h42);
    probe(16'hFBFF, 1'b1);
    chk("R5 F000-FBFF mapped", {12'd0, phys_addr}, 32'h42BFF);
    probe(16'hFC10, 1'b1);
    chk("R5 io region", {31'd0, io_sel}, 1);
    // R6 top window with nonzero map
    probe(16'hFF7E, 1'b0);
    chk("R6 top window", {18'd0, rom_offset}, 32'h3F7E);
    // R8 disable: task bits ignored
    do_ctl(8'hC9);
    probe(16'h2000, 1'b0);
    chk("R8 default in force", {12'd0, phys_addr}, 32'h02000);
    // R9 other task untouched
    do_ctl(8'h86);
    probe(16'h2000, 1'b0);
    chk("R9 task6 untouched", {12'd0, phys_addr}, 32'h00000);
    // R10 NMI assert
    do_ctl(8'h06);
    chk("R10 nmi asserted", {31'd0, nmi_n}, 0);
    do_ctl(8'h85);
    probe(16'h2000, 1'b0);
    chk("R9 task5 kept", {31'd0, rom_sel}, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) do_ctl(8'($urandom));
      else if (op < 4) do_win(4'($urandom), rnd_page());
      else probe(16'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule